// File: doc/BRIEF.md
# Strobe Delay Calibration Sweeper

This block tunes the delay setting of a memory data strobe. After a start pulse it walks an 8-bit setting index upward from zero. It drives each index onto the delay control in Gray code, so that neighbouring settings differ in one bit. For every index it raises a request to an external pattern tester and then waits. The tester writes and reads back its word pattern and answers with a one-cycle result strobe that carries pass or fail. The block records the first passing index as the low edge of the working window. It then keeps stepping until the first failing index, which becomes the high edge. If the sweep runs off the end of the range, the high edge is taken as 255.

When the search ends, the block parks the delay control at a point two thirds of the way from the low edge to the high edge, in Gray code. If no index ever passes, it drives a fixed fallback raw code instead and reports that nothing was found. The request/result pair works as a simple stream with one transaction in flight. The request stays high until a result strobe arrives, and the tester may take any number of cycles to answer. A result strobe that arrives while no request is pending is dropped. There is no other back-pressure.

Top module: `strobe_cal_sweeper`

## Requirements
- R1: After reset, test_req, done and found are 0, delay_gray is 0x00 and final_index is 0xFF.
- R2: During a sweep the tested indices ascend by one from 0. While a request is pending for index i, delay_gray equals i ^ (i >> 1) and does not change.
- R3: At most one request is pending. test_req falls in the cycle after a result strobe is accepted and rises again at least one cycle later. A result strobe while test_req is low has no effect.
- R4: The low edge is the first index in 0..254 that reports pass. No index above 254 is ever tested.
- R5: The high edge is the first failing index after the low edge, or 255 if every later index up to 254 passes. No request is raised after the high edge is found.
- R6: When a window is found, found is 1. final_index equals low + floor(2 × (high − low) / 3), computed without overflow, and delay_gray equals final_index ^ (final_index >> 1).
- R7: If no index passes, exactly 255 requests are made. found is 0, delay_gray is the raw fallback code 0x59 and final_index is 0xFF.
- R8: done rises when the search ends and holds, together with delay_gray and final_index, until the next start. A start while idle or done begins a fresh sweep at index 0.
- R9: A start pulse while a sweep is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration sweep (ignored while busy) |
| test_req | output | 1 | Request a pattern check at the current setting |
| result_valid | input | 1 | One-cycle strobe: the pattern check has finished |
| result_pass | input | 1 | Outcome of the check, valid with result_valid |
| delay_gray | output | 8 | Delay control code: the index under test in Gray code, then the final setting |
| done | output | 1 | Search finished, outputs hold |
| found | output | 1 | A passing window exists (meaningful with done) |
| final_index | output | 8 | Chosen binary index, 0xFF when nothing was found |

## Verification
A wrong step in the index counter shows as a Gray code at the very next request that does not match the tester's own count. It also gives a request total that differs from the count worked out from the pass window, so the error is visible within one request. An edge register that is latched wrongly, or a search phase that is wrong, leaves done and final_index correct in form but off in value. The value is compared as soon as done rises. A result strobe that is accepted when no request is pending would shift every later index by one. Dropped or extra start pulses show up as a changed request total or as done failing to hold.

// File: rtl/scal_pkg.sv
package scal_pkg;
  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_ARM   = 2'd1,
    SC_PROBE = 2'd2,
    SC_DONE  = 2'd3
  } scal_state_e;
endpackage

// File: rtl/scal_gray_enc.sv
module scal_gray_enc #(
  parameter int W = 8
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o
);
  // Adjacent binary values map to codes one bit apart.
  assign gray_o = bin_i ^ (bin_i >> 1);
endmodule

// File: rtl/scal_window_calc.sv
module scal_window_calc #(
  parameter int W = 8
) (
  input  logic [W-1:0] low_i,
  input  logic [W-1:0] high_i,
  output logic [W-1:0] point_o
);
  // Two extra bits keep twice the span from wrapping.
  localparam int CW = W + 2;

  logic [W-1:0]  span;
  logic [CW-1:0] span2;
  logic [CW-1:0] frac;

  assign span    = high_i - low_i;
  assign span2   = {1'b0, span, 1'b0};
  assign frac    = span2 / CW'(3);
  assign point_o = W'({2'b00, low_i} + frac);
endmodule

// File: rtl/scal_seq.sv
module scal_seq
  import scal_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         result_valid,
  input  logic         result_pass,
  output logic         req_o,
  output logic         done_o,
  output logic         found_o,
  output logic [W-1:0] idx_o,
  output logic [W-1:0] low_o,
  output logic [W-1:0] high_o
);
  localparam logic [W-1:0] TOP_IDX  = {W{1'b1}};
  localparam logic [W-1:0] LAST_IDX = TOP_IDX - W'(1);

  scal_state_e state_q;
  logic         hi_phase_q;
  logic         found_q;
  logic [W-1:0] idx_q, low_q, high_q;

  wire accept  = (state_q == SC_PROBE) && result_valid;
  wire at_last = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= SC_IDLE;
      hi_phase_q <= 1'b0;
      found_q    <= 1'b0;
      idx_q      <= '0;
      low_q      <= '0;
      high_q     <= '0;
    end else begin
      case (state_q)
        SC_IDLE, SC_DONE: begin
          if (start) begin
            state_q    <= SC_ARM;
            hi_phase_q <= 1'b0;
            found_q    <= 1'b0;
            idx_q      <= '0;
          end
        end
        SC_ARM: state_q <= SC_PROBE;
        SC_PROBE: begin
          if (accept) begin
            if (!hi_phase_q) begin
              // searching for the first passing index
              if (result_pass) begin
                low_q <= idx_q;
                if (at_last) begin
                  high_q  <= TOP_IDX;
                  found_q <= 1'b1;
                  state_q <= SC_DONE;
                end else begin
                  idx_q      <= idx_q + W'(1);
                  hi_phase_q <= 1'b1;
                  state_q    <= SC_ARM;
                end
              end else if (at_last) begin
                low_q   <= TOP_IDX;
                high_q  <= TOP_IDX;
                state_q <= SC_DONE;
              end else begin
                idx_q   <= idx_q + W'(1);
                state_q <= SC_ARM;
              end
            end else begin
              // searching for the first failing index above the low edge
              if (!result_pass) begin
                high_q  <= idx_q;
                found_q <= 1'b1;
                state_q <= SC_DONE;
              end else if (at_last) begin
                high_q  <= TOP_IDX;
                found_q <= 1'b1;
                state_q <= SC_DONE;
              end else begin
                idx_q   <= idx_q + W'(1);
                state_q <= SC_ARM;
              end
            end
          end
        end
        default: state_q <= SC_IDLE;
      endcase
    end
  end

  assign req_o   = (state_q == SC_PROBE);
  assign done_o  = (state_q == SC_DONE);
  assign found_o = found_q;
  assign idx_o   = idx_q;
  assign low_o   = low_q;
  assign high_o  = high_q;
endmodule

// File: rtl/strobe_cal_sweeper.sv
module strobe_cal_sweeper #(
  parameter int           W            = 8,
  parameter logic [W-1:0] DEFAULT_CODE = W'(8'h59)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         test_req,
  input  logic         result_valid,
  input  logic         result_pass,
  output logic [W-1:0] delay_gray,
  output logic         done,
  output logic         found,
  output logic [W-1:0] final_index
);
  localparam logic [W-1:0] NONE_IDX = {W{1'b1}};

  logic [W-1:0] idx, low_edge, high_edge, point;
  logic [W-1:0] idx_gray, point_gray;
  logic         seq_done, seq_found;

  scal_seq #(.W(W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .result_valid (result_valid),
    .result_pass  (result_pass),
    .req_o        (test_req),
    .done_o       (seq_done),
    .found_o      (seq_found),
    .idx_o        (idx),
    .low_o        (low_edge),
    .high_o       (high_edge)
  );

  scal_window_calc #(.W(W)) u_calc (
    .low_i   (low_edge),
    .high_i  (high_edge),
    .point_o (point)
  );

  scal_gray_enc #(.W(W)) u_gray_idx   (.bin_i(idx),   .gray_o(idx_gray));
  scal_gray_enc #(.W(W)) u_gray_point (.bin_i(point), .gray_o(point_gray));

  always_comb begin
    if (!seq_done)      delay_gray = idx_gray;
    else if (seq_found) delay_gray = point_gray;
    else                delay_gray = DEFAULT_CODE;
  end

  assign done        = seq_done;
  assign found       = seq_found;
  assign final_index = seq_found ? point : NONE_IDX;
endmodule

// File: rtl/strobe_cal_sweeper_chk.sv
module strobe_cal_sweeper_chk #(
  parameter int           W            = 8,
  parameter logic [W-1:0] DEFAULT_CODE = W'(8'h59)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         test_req,
  input logic         result_valid,
  input logic         result_pass,
  input logic [W-1:0] delay_gray,
  input logic         done,
  input logic         found,
  input logic [W-1:0] final_index
);
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    test_req && result_valid |=> !test_req); // R3

  AST_CODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    test_req && !result_valid |=> test_req && $stable(delay_gray)); // R2

  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(test_req) && $past(result_valid) && !done
      |-> $countones(delay_gray ^ $past(delay_gray)) == 1); // R2

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(delay_gray) && $stable(final_index)); // R8

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    test_req && start && !result_valid |=> test_req); // R9

  AST_FOUND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> done); // R6
endmodule

bind strobe_cal_sweeper strobe_cal_sweeper_chk #(.W(W), .DEFAULT_CODE(DEFAULT_CODE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .test_req     (test_req),
  .result_valid (result_valid),
  .result_pass  (result_pass),
  .delay_gray   (delay_gray),
  .done         (done),
  .found        (found),
  .final_index  (final_index)
);

// File: tb/strobe_cal_sweeper_test.sv
`timescale 1ns/1ps
module strobe_cal_sweeper_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       result_valid = 1'b0;
  logic       result_pass = 1'b0;
  logic       test_req, done, found;
  logic [7:0] delay_gray, final_index;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  strobe_cal_sweeper uut (
    .clk(clk), .rst_n(rst_n), .start(start), .test_req(test_req),
    .result_valid(result_valid), .result_pass(result_pass),
    .delay_gray(delay_gray), .done(done), .found(found),
    .final_index(final_index)
  );

  function automatic logic [7:0] gray8(int k);
    logic [7:0] b = 8'(k);
    return b ^ (b >> 1);
  endfunction

  task automatic check(string req, int actual, int expected, string what);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, actual, expected);
    end
  endtask

  // Tester model: indices lo..hi pass, all others fail.
  function automatic bit in_win(int k, int lo, int hi);
    return (k >= lo) && (k <= hi);
  endfunction

  task automatic run_case(string name, int lo, int hi, int lat, int glitch_at);
    int e_low, e_high, e_tests, e_final, n, exp_i, bad;
    bit e_found;
    e_low = 255; e_high = 255; e_tests = 0;
    for (int k = 0; k <= 254; k++) begin
      e_tests++;
      if (in_win(k, lo, hi)) begin e_low = k; break; end
    end
    if (e_low < 255)
      for (int k = e_low + 1; k <= 254; k++) begin
        e_tests++;
        if (!in_win(k, lo, hi)) begin e_high = k; break; end
      end
    e_found = (e_low < 255);
    e_final = e_found ? e_low + (2 * (e_high - e_low)) / 3 : 255;

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0; exp_i = 0; bad = 0;
    while (!done && !finished) begin
      if (test_req) begin
        if (delay_gray != gray8(exp_i) && bad == 0) begin
          bad = 1;
          check("R2", delay_gray, gray8(exp_i), {name, " code at request"});
        end
        if (n == glitch_at) begin
          start = 1'b1;
          @(negedge clk) start = 1'b0;
        end
        repeat (lat) @(negedge clk);
        result_pass  = in_win(exp_i, lo, hi);
        result_valid = 1'b1;
        @(negedge clk);
        result_valid = 1'b0;
        check("R3", test_req, 0, {name, " request released"});
        n++; exp_i++;
      end else begin
        @(negedge clk);
      end
    end
    check("R2", bad, 0, {name, " gray sequence"});
    if (e_found) begin
      check("R4", n, e_tests, {name, " request count low/high search"});
      check("R6", found, 1, {name, " found"});
      check("R6", final_index, e_final, {name, " final index"});
      check("R6", delay_gray, gray8(e_final), {name, " final code"});
    end else begin
      check("R7", n, 255, {name, " request count"});
      check("R7", found, 0, {name, " found"});
      check("R7", delay_gray, 8'h59, {name, " fallback code"});
      check("R7", final_index, 8'hFF, {name, " final index"});
    end
    // R5: nothing more is requested and done holds
    repeat (5) @(negedge clk);
    check("R5", test_req, 0, {name, " no request after end"});
    check("R8", done, 1, {name, " done held"});
  endtask

  task automatic test_reset;
    @(negedge clk);
    check("R1", test_req, 0, "reset test_req");
    check("R1", done, 0, "reset done");
    check("R1", found, 0, "reset found");
    check("R1", delay_gray, 0, "reset delay_gray");
    check("R1", final_index, 8'hFF, "reset final_index");
  endtask

  task automatic test_stray_idle;
    @(negedge clk) begin result_valid = 1'b1; result_pass = 1'b1; end
    @(negedge clk) result_valid = 1'b0;
    check("R3", done, 0, "stray result in idle: done");
    check("R3", delay_gray, 0, "stray result in idle: code");
    check("R3", test_req, 0, "stray result in idle: req");
  endtask

  task automatic test_stray_done;
    logic [7:0] g, f;
    g = delay_gray; f = final_index;
    @(negedge clk) begin result_valid = 1'b1; result_pass = 1'b0; end
    @(negedge clk) result_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R3", delay_gray, g, "stray result when done: code");
    check("R8", final_index, f, "stray result when done: index");
    check("R8", done, 1, "stray result when done: done");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_stray_idle();
    run_case("mid window", 10, 40, 0, -1);
    test_stray_done();
    run_case("all pass", 0, 254, 2, -1);
    run_case("no pass", 300, 300, 0, -1);
    run_case("last only", 254, 254, 0, -1);
    run_case("single + busy start R9", 100, 100, 1, 50);
    run_case("narrow", 5, 7, 3, 2);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog: run did not end");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule